// File: doc/BRIEF.md
# I2C Register-Write Master

This block is a bus master for a two-wire serial bus. It performs one register write for each request. When it accepts a request it produces a start condition. It then shifts out three bytes: the 7-bit target address with a write direction bit, the register index, and the data value. A stop condition follows. The block drives both lines through open-drain enables. An enable of 1 pulls the line low, and an enable of 0 lets the external pull-up take the line high. The block reads SDA back so that it can check the acknowledge bit that the target returns after each byte.

The bus timing is built from quarter-period ticks. The parameter `QDIV` gives the number of system clocks in one quarter of an SCL period. The default of 312 gives roughly 40 kHz from a 50 MHz system clock. An acknowledge that reads high ends the transfer at once with a stop, and the remaining bytes are not sent. At the end the block gives a one-cycle `done_o` pulse and sets `ack_err_o`, which holds its value until the next request is accepted.

Top module: `i2c_regwr_master`

## Requirements
- R1: After reset both enables are 0, so both lines are high, and `busy_o`, `done_o` and `ack_err_o` are all 0.
- R2: `start_i` is accepted only while the block is idle. `busy_o` rises on the clock edge that accepts it. A `start_i` pulse during a transfer has no effect on the bus, on the bytes sent, or on the outcome.
- R3: After acceptance both lines stay released for two quarters. SDA is then pulled low while SCL stays high for two more quarters, which forms the start condition. One quarter lasts `QDIV` clocks.
- R4: The bytes appear in this order: `{dev_addr_i, 1'b0}`, then `reg_idx_i`, then `wr_data_i`. Each byte is sent most significant bit first. Each bit is placed on SDA one quarter after SCL falls. The address 0x25 with index 0x01 and data 0x08 therefore puts the bytes 0x4A, 0x01, 0x08 on the bus.
- R5: During the byte slots SDA never changes while SCL is high.
- R6: In the ninth slot of each byte the master releases SDA. It samples SDA, through a synchronizer, at the midpoint of the SCL high time. A high level counts as a not-acknowledge.
- R7: A not-acknowledge in any slot is followed directly by the stop condition, and no further byte is sent.
- R8: The stop condition has four steps. With SCL low, SDA is pulled low. SCL is then released. After one more quarter, SDA is released while SCL is high.
- R9: `done_o` is high for exactly one cycle, in the cycle where `busy_o` falls. This happens 4·QDIV·(slots+2) clocks after acceptance, where slots is 27 for a full transfer. In that cycle `ack_err_o` is 1 if a not-acknowledge was seen. The flag keeps that value until the next acceptance clears it.
- R10: Each SCL pulse in the byte slots is low for two quarters and high for two quarters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a register write |
| dev_addr_i | input | 7 | Target address, latched at acceptance |
| reg_idx_i | input | 8 | Register index, latched at acceptance |
| wr_data_i | input | 8 | Data byte, latched at acceptance |
| sda_i | input | 1 | SDA level read back from the bus |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ack_err_o | output | 1 | A not-acknowledge ended the last transfer |

## Verification
Every result of this block falls on a fixed cycle counted from the accepting edge. The start-condition fall is due at 2·QDIV. Each data bit is due at 4·QDIV·(slot+1)+QDIV. The acknowledge sample reads the bus two synchronizer stages before the edge at 3·QDIV into the ack slot. `done_o` is due at 4·QDIV·(slots+2). The bench counts its own cycle index from the same accepting edge, derives the expected line levels, `busy_o`, `done_o` and `ack_err_o` for that index, and compares them on the falling clock edge, half a period after the registers update. A separate bus monitor decodes start, stop and the bytes from the line levels alone, so a wrong byte order or a missing stop shows up independently of the cycle count.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  // Fixed frame geometry of a register write.
  localparam int unsigned ADDR_W      = 7;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BYTES = 3;
  localparam int unsigned SLOT_BITS   = BYTE_W + 1;
  localparam int unsigned FRAME_W     = FRAME_BYTES * BYTE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_BITS  = 2'd2,
    SEQ_STOP  = 2'd3
  } seq_state_t;

  // Packs the three bytes, first byte on the bus in the top bits.
  function automatic logic [FRAME_W-1:0] frame_pack(
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] idx,
    input logic [BYTE_W-1:0] data
  );
    return {addr, 1'b0, idx, data};
  endfunction

  // SCL release for a given state and quarter: high half is quarters 2 and 3.
  function automatic logic scl_released(input seq_state_t st, input logic [1:0] qtr);
    logic rel;
    case (st)
      SEQ_BITS, SEQ_STOP: rel = qtr[1];
      default:            rel = 1'b1;
    endcase
    return rel;
  endfunction

  // Total quarters of a transfer with a given number of bit slots.
  function automatic int unsigned txn_quarters(input int unsigned slots);
    return 4 * (slots + 2);
  endfunction

endpackage

// File: rtl/i2cw_qtick.sv
module i2cw_qtick #(
  parameter int unsigned QDIV = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || tick_o) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2cw_slot_ctr.sv
module i2cw_slot_ctr #(
  parameter int unsigned NBYTES = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [NBYTES*BYTE_W-1:0] frame_i,
  input  logic                     adv_i,
  output logic                     cur_bit_o,
  output logic                     ack_slot_o,
  output logic                     last_slot_o
);
  localparam int unsigned FW    = NBYTES * BYTE_W;
  localparam int unsigned SLOTS = BYTE_W + 1;
  localparam int unsigned BIW   = $clog2(SLOTS);
  localparam int unsigned BYW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [FW-1:0]  sh_q;
  logic [BIW-1:0] bit_q;
  logic [BYW-1:0] byte_q;

  assign cur_bit_o   = sh_q[FW-1];
  assign ack_slot_o  = (bit_q == BIW'(BYTE_W));
  assign last_slot_o = ack_slot_o && (byte_q == BYW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      bit_q  <= '0;
      byte_q <= '0;
    end else if (adv_i) begin
      if (ack_slot_o) begin
        bit_q  <= '0;
        byte_q <= byte_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
        sh_q  <= {sh_q[FW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2c_regwr_master.sv
module i2c_regwr_master
  import i2cw_pkg::*;
#(
  parameter int unsigned QDIV        = 312,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] reg_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_err_o
);
  seq_state_t st_q;
  logic [1:0] qtr_q;
  logic       scl_oe_q, sda_oe_q, done_q, err_q, nack_q;

  // Named internal events, used by the bound checker.
  logic ev_accept, ev_tick, ev_sample, ev_slot_end, in_bits;
  logic sda_s, cur_bit, ack_slot, last_slot;

  assign busy_o    = (st_q != SEQ_IDLE);
  assign in_bits   = (st_q == SEQ_BITS);
  assign ev_accept = start_i && !busy_o;
  assign ev_sample   = ev_tick && in_bits && ack_slot && (qtr_q == 2'd2);
  assign ev_slot_end = ev_tick && in_bits && (qtr_q == 2'd3);

  i2cw_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear_i(ev_accept), .run_i(busy_o), .tick_o(ev_tick)
  );

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  i2cw_slot_ctr #(.NBYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .load_i(ev_accept),
    .frame_i(frame_pack(dev_addr_i, reg_idx_i, wr_data_i)),
    .adv_i(ev_slot_end), .cur_bit_o(cur_bit), .ack_slot_o(ack_slot),
    .last_slot_o(last_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      qtr_q    <= 2'd0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_accept) begin
        st_q     <= SEQ_START;
        qtr_q    <= 2'd0;
        scl_oe_q <= 1'b0;
        sda_oe_q <= 1'b0;
        err_q    <= 1'b0;
        nack_q   <= 1'b0;
      end else if (ev_tick) begin
        qtr_q <= qtr_q + 2'd1;
        case (st_q)
          SEQ_START: begin
            if (qtr_q == 2'd1) sda_oe_q <= 1'b1;       // start: SDA low, SCL high
            if (qtr_q == 2'd3) begin
              st_q     <= SEQ_BITS;
              scl_oe_q <= !scl_released(SEQ_BITS, 2'd0);
            end
          end
          SEQ_BITS: begin
            case (qtr_q)
              2'd0: sda_oe_q <= ack_slot ? 1'b0 : !cur_bit; // bit one quarter after SCL fall
              2'd1: scl_oe_q <= !scl_released(SEQ_BITS, 2'd2);
              2'd2: if (ack_slot) nack_q <= sda_s;        // mid-high sample
              default: begin
                scl_oe_q <= 1'b1;
                if (ack_slot && (nack_q || last_slot)) st_q <= SEQ_STOP;
              end
            endcase
          end
          SEQ_STOP: begin
            case (qtr_q)
              2'd0: sda_oe_q <= 1'b1;
              2'd1: scl_oe_q <= !scl_released(SEQ_STOP, 2'd2);
              2'd2: sda_oe_q <= 1'b0;                    // stop: SDA rises, SCL high
              default: begin
                st_q   <= SEQ_IDLE;
                done_q <= 1'b1;
                err_q  <= nack_q;
              end
            endcase
          end
          default: st_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign done_o    = done_q;
  assign ack_err_o = err_q;
endmodule

// File: rtl/i2cw_regwr_chk.sv
module i2cw_regwr_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic ack_err_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic in_bits,
  input logic ev_sample,
  input logic ev_accept
);
  localparam logic [5:0] FULL_RISES = 6'd28;

  logic       scl_oe_d;
  logic [5:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe_d <= 1'b0;
      rises    <= '0;
    end else begin
      scl_oe_d <= scl_oe_o;
      if (ev_accept)                  rises <= '0;
      else if (scl_oe_d && !scl_oe_o) rises <= rises + 6'd1;
    end
  end

  // R5
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bits && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  // R3
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_o) && !scl_oe_o) |-> !in_bits);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> !sda_oe_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_err_o) |-> (done_o || $rose(busy_o)));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R7
  full_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ack_err_o) |-> (rises == FULL_RISES));
endmodule

bind i2c_regwr_master i2cw_regwr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .ack_err_o(ack_err_o), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .in_bits(in_bits), .ev_sample(ev_sample),
  .ev_accept(ev_accept)
);

// File: tb/i2c_regwr_master_tb.sv
module i2c_regwr_master_tb_top;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] idx_i = '0;
  logic [7:0] dat_i = '0;
  logic [2:0] cur_ack = 3'b111;
  logic scl_oe, sda_oe, busy, done, ack_err;
  logic slave_pull;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slave_pull);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_regwr_master #(.QDIV(Q), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_addr_i(addr_i),
    .reg_idx_i(idx_i), .wr_data_i(dat_i), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .ack_err_o(ack_err)
  );

  // ---------------- reference model ----------------
  int t = -1;
  int end_t = 0;
  int nslots = 27;
  logic [7:0] mb [3];
  logic [2:0] ackm = 3'b111;
  logic last_nack = 1'b0;

  function automatic int slots_for(input logic [2:0] m);
    for (int j = 0; j < 3; j++) if (!m[j]) return 9 * (j + 1);
    return 27;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t <= -1;
    end else if ((t < 0 || t == end_t) && start_i) begin
      t <= 0;
      mb[0] <= {addr_i, 1'b0};
      mb[1] <= idx_i;
      mb[2] <= dat_i;
      ackm <= cur_ack;
      nslots <= slots_for(cur_ack);
      end_t <= 4 * Q * (slots_for(cur_ack) + 2);
      last_nack <= (cur_ack != 3'b111);
    end else if (t >= 0) begin
      t <= (t == end_t) ? -1 : t + 1;
    end
  end

  function automatic logic mbit(input int k);
    if (k % 9 == 8) return 1'b1;
    return mb[k / 9][7 - (k % 9)];
  endfunction

  function automatic logic exp_scl(input int tt);
    int s;
    if (tt < 0 || tt >= end_t || tt < 4 * Q) return 1'b1;
    s = tt - 4 * Q;
    return ((s % (4 * Q)) / Q) >= 2;
  endfunction

  function automatic logic exp_msda(input int tt);
    int s, k, p;
    if (tt < 0 || tt >= end_t) return 1'b1;
    if (tt < 4 * Q) return (tt < 2 * Q);
    s = tt - 4 * Q;
    k = s / (4 * Q);
    p = (s % (4 * Q)) / Q;
    if (k < nslots) begin
      if (p == 0) return (k == 0) ? 1'b0 : mbit(k - 1);
      return mbit(k);
    end
    return (p == 0 || p == 3);
  endfunction

  function automatic logic spull(input int tt);
    int s, k, p;
    if (tt < 4 * Q || tt >= end_t) return 1'b0;
    s = tt - 4 * Q;
    k = s / (4 * Q);
    p = (s % (4 * Q)) / Q;
    return (k < nslots) && (k % 9 == 8) && (p >= 1) && ackm[k / 9];
  endfunction

  function automatic string line_tag(input int tt);
    int s, k;
    if (tt < 0 || tt >= end_t) return "R1";
    if (tt < 4 * Q) return "R3";
    s = tt - 4 * Q;
    k = s / (4 * Q);
    if (k >= nslots) return (nslots < 27) ? "R7 R8" : "R8";
    if (k % 9 == 8) return "R6";
    return "R4 R5 R10";
  endfunction

  assign slave_pull = (t >= 0) ? spull(t) : 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  // ---------------- bus monitor ----------------
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] mon_sh = '0;
  int mon_n = 0;
  int starts = 0, stops = 0;
  logic [7:0] mon_q [$];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(scl_line == exp_scl(t), {line_tag(t), " scl"}, scl_line, exp_scl(t));
      check(sda_line == (exp_msda(t) & ~spull(t)), {line_tag(t), " sda"},
            sda_line, exp_msda(t) & ~spull(t));
      check(busy == (t >= 0 && t < end_t), "R2 busy", busy, (t >= 0 && t < end_t));
      check(done == (t >= 0 && t == end_t), "R9 done", done, (t >= 0 && t == end_t));
      check(ack_err == ((t >= 0 && t < end_t) ? 1'b0 : last_nack), "R9 ack_err",
            ack_err, (t >= 0 && t < end_t) ? 1'b0 : last_nack);
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        starts++;
        mon_n = 0;
      end
      if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
      if (!prev_scl && scl_line) begin
        if (mon_n % 9 < 8) mon_sh = {mon_sh[6:0], sda_line};
        if (mon_n % 9 == 7) mon_q.push_back(mon_sh);
        mon_n++;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                         input logic [2:0] m, input int glitch_at);
    int nsent;
    logic [7:0] expb [3];
    expb[0] = {a, 1'b0};
    expb[1] = r;
    expb[2] = d;
    nsent = slots_for(m) / 9;
    mon_q.delete();
    starts = 0;
    stops = 0;
    @(negedge clk);
    addr_i = a; idx_i = r; dat_i = d; cur_ack = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (glitch_at > 0) begin
      repeat (glitch_at) @(negedge clk);
      addr_i = ~a; idx_i = ~r; dat_i = ~d; cur_ack = 3'b000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_i = a; idx_i = r; dat_i = d; cur_ack = m;
    end
    while (!(t >= 0 && t == end_t) && !finished) @(negedge clk);
    // R9: done with ack_err reflecting the acknowledge outcome
    check(done == 1'b1 && ack_err == (m != 3'b111), "R9 end", {done, ack_err},
          {1'b1, (m != 3'b111)});
    @(negedge clk);
    // R3 R8: exactly one start and one stop seen on the lines
    check(starts == 1, "R3 starts", starts, 1);
    check(stops == 1, "R8 stops", stops, 1);
    // R7: bytes after a not-acknowledge are not sent
    check(mon_q.size() == nsent, "R7 byte count", mon_q.size(), nsent);
    for (int j = 0; j < nsent && j < mon_q.size(); j++)
      check(mon_q[j] == expb[j], "R4 R2 byte", mon_q[j], expb[j]);
    repeat (3) @(negedge clk);
    // R9: flag held after the transfer
    check(ack_err == (m != 3'b111), "R9 hold", ack_err, (m != 3'b111));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_line && sda_line && !busy && !done && !ack_err, "R1 reset",
          {scl_line, sda_line, busy, done, ack_err}, 5'b11000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl_line && sda_line && !busy, "R1 idle", {scl_line, sda_line, busy}, 3'b110);
    run_txn(7'h25, 8'h01, 8'h08, 3'b111, 0);  // 0x4A 0x01 0x08
    run_txn(7'h7F, 8'hFF, 8'h00, 3'b111, 0);
    run_txn(7'h00, 8'h5A, 8'hA5, 3'b111, 0);
    run_txn(7'h25, 8'h01, 8'h08, 3'b000, 0);  // address not acknowledged
    run_txn(7'h12, 8'h34, 8'h56, 3'b001, 0);  // index not acknowledged
    run_txn(7'h12, 8'h34, 8'h56, 3'b011, 0);  // data not acknowledged
    run_txn(7'h6C, 8'hC3, 8'h3C, 3'b111, 40); // R2: request during busy ignored
    run_txn(7'h01, 8'h80, 8'h01, 3'b111, 0);  // R9: flag cleared by new request
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule